// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block forecasts whether a conditional branch will be taken. It has two component predictors. The first is indexed by the outcomes of the most recent branches in the whole program. The second is indexed by the recent outcomes of the branch being looked up. A table of 2-bit saturating counters, indexed by branch address, decides for each branch which component's answer to trust. The lookup port is purely combinational. It returns the final direction, both component directions, the chooser decision, and the two history values that were used.

The fetch logic keeps the returned history snapshots and component directions alongside the branch. When the branch resolves, it hands them back on the update port together with the real outcome. On that clock edge all three structures are trained. Both component tables are trained on every update. The chooser moves only when the two components disagreed in correctness. Program-counter inputs carry word addresses, so the byte-alignment bits are already dropped. Each table index is the XOR fold of the whole address down to that table's index width.

Top module: `tourney_bp`

## Requirements
- R1: After reset the global history and every per-branch history are zero, every component counter is 01 (weakly not-taken), and every chooser counter is 01 (weakly local), so every lookup returns all predictions 0.
- R2: Each component counter is a 2-bit saturating counter: a taken outcome adds one up to 3, a not-taken outcome subtracts one down to 0, and its prediction is the counter's upper bit (1 = taken).
- R3: Each valid update shifts the outcome into bit 0 of the global history. lookupGhist shows that history, and it directly selects the global counter read at lookup; at update the counter at updGhist is trained.
- R4: A per-branch history slot is picked by the XOR fold of the PC into LHT_IDX_W bits. Each valid update shifts the outcome into bit 0 of its slot. lookupLhist shows the slot, and its value selects the local counter; at update the counter at updLhist is trained.
- R5: The chooser counter, picked by the XOR fold of the PC into SEL_IDX_W bits, adds one (saturating at 3) when only the global prediction matched the outcome, and subtracts one (saturating at 0) when only the local one did.
- R6: When both component predictions matched the outcome, or neither did, the chooser counter is left unchanged.
- R7: predUseGlobal is the chooser counter's upper bit, and predTaken equals predGlobal when it is 1 and predLocal when it is 0.
- R8: Both component counters are trained on every valid update, whichever component the chooser favoured.
- R9: With updValid low, no history, counter or chooser state changes.
- R10: A lookup in the same cycle as an update reflects the state before that update; the update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | Word address of the branch being predicted |
| predTaken | output | 1 | Final direction (1 = taken) |
| predGlobal | output | 1 | Global component's direction |
| predLocal | output | 1 | Local component's direction |
| predUseGlobal | output | 1 | Chooser decision (1 = global) |
| lookupGhist | output | GH_W | Global history snapshot used at lookup |
| lookupLhist | output | LH_W | Per-branch history snapshot used at lookup |
| updValid | input | 1 | Update strobe |
| updPc | input | PC_W | Word address of the resolved branch |
| updTaken | input | 1 | Actual outcome |
| updGhist | input | GH_W | Global history snapshot from lookup |
| updLhist | input | LH_W | Per-branch history snapshot from lookup |
| updPredGlobal | input | 1 | Global direction given at lookup |
| updPredLocal | input | 1 | Local direction given at lookup |

## Verification
A lookup and a training update can fall in the same cycle, for the same branch slot and the same history. The bench provokes this on nearly every cycle: each step of its vector table holds the lookup address and drives the update in the same clock. One directed step also targets the same slot whose new history must show. The combinational outputs are judged just before the edge, where they must still show the old state, and again one cycle later, where the new histories and counters must have appeared.

// File: rtl/tourney_pkg.sv
package tourney_pkg;

  typedef struct packed {
    logic trainGlobal;
    logic trainLocal;
    logic shiftHist;
    logic selUp;
    logic selDown;
  } bpStrobes_t;

  function automatic logic [1:0] satStep(input logic [1:0] cnt, input logic up);
    if (up) return (cnt == 2'b11) ? cnt : cnt + 2'd1;
    else    return (cnt == 2'b00) ? cnt : cnt - 2'd1;
  endfunction

endpackage

// File: rtl/tourney_ctl.sv
module tourney_ctl
  import tourney_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updPredGlobal,
  input  logic       updPredLocal,
  output bpStrobes_t strobes
);
  logic globalRight;
  logic localRight;

  always_comb begin
    globalRight = (updPredGlobal == updTaken);
    localRight  = (updPredLocal == updTaken);
    strobes.trainGlobal = updValid;
    strobes.trainLocal  = updValid;
    strobes.shiftHist   = updValid;
    strobes.selUp       = updValid && globalRight && !localRight;
    strobes.selDown     = updValid && localRight && !globalRight;
  end
endmodule

// File: rtl/tourney_dp.sv
module tourney_dp
  import tourney_pkg::*;
#(
  parameter int PC_W      = 30,
  parameter int GH_W      = 10,
  parameter int LH_W      = 10,
  parameter int LHT_IDX_W = 10,
  parameter int SEL_IDX_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  bpStrobes_t      strobes,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predGlobal,
  output logic            predLocal,
  output logic            predUseGlobal,
  output logic [GH_W-1:0] lookupGhist,
  output logic [LH_W-1:0] lookupLhist,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [GH_W-1:0] updGhist,
  input  logic [LH_W-1:0] updLhist
);
  localparam int GCTR_N = 1 << GH_W;
  localparam int LCTR_N = 1 << LH_W;
  localparam int LHT_N  = 1 << LHT_IDX_W;
  localparam int SEL_N  = 1 << SEL_IDX_W;
  localparam logic [1:0] CTR_INIT = 2'b01;

  logic [1:0]      globalCtr [GCTR_N];
  logic [1:0]      localCtr  [LCTR_N];
  logic [LH_W-1:0] histTable [LHT_N];
  logic [1:0]      chooser   [SEL_N];
  logic [GH_W-1:0] globalHist;

  function automatic logic [LHT_IDX_W-1:0] foldHist(input logic [PC_W-1:0] pc);
    logic [LHT_IDX_W-1:0] acc = '0;
    for (int i = 0; i < PC_W; i++) acc[i % LHT_IDX_W] ^= pc[i];
    return acc;
  endfunction

  function automatic logic [SEL_IDX_W-1:0] foldSel(input logic [PC_W-1:0] pc);
    logic [SEL_IDX_W-1:0] acc = '0;
    for (int i = 0; i < PC_W; i++) acc[i % SEL_IDX_W] ^= pc[i];
    return acc;
  endfunction

  logic [LHT_IDX_W-1:0] lkHistIdx, upHistIdx;
  logic [SEL_IDX_W-1:0] lkSelIdx, upSelIdx;

  always_comb begin
    lkHistIdx     = foldHist(lookupPc);
    upHistIdx     = foldHist(updPc);
    lkSelIdx      = foldSel(lookupPc);
    upSelIdx      = foldSel(updPc);
    lookupGhist   = globalHist;
    lookupLhist   = histTable[lkHistIdx];
    predGlobal    = globalCtr[globalHist][1];
    predLocal     = localCtr[lookupLhist][1];
    predUseGlobal = chooser[lkSelIdx][1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) globalHist <= '0;
    else if (strobes.shiftHist) globalHist <= {globalHist[GH_W-2:0], updTaken};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < GCTR_N; i++) globalCtr[i] <= CTR_INIT;
    end else if (strobes.trainGlobal) begin
      globalCtr[updGhist] <= satStep(globalCtr[updGhist], updTaken);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LCTR_N; i++) localCtr[i] <= CTR_INIT;
    end else if (strobes.trainLocal) begin
      localCtr[updLhist] <= satStep(localCtr[updLhist], updTaken);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LHT_N; i++) histTable[i] <= '0;
    end else if (strobes.shiftHist) begin
      histTable[upHistIdx] <= {histTable[upHistIdx][LH_W-2:0], updTaken};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SEL_N; i++) chooser[i] <= CTR_INIT;
    end else if (strobes.selUp || strobes.selDown) begin
      chooser[upSelIdx] <= satStep(chooser[upSelIdx], strobes.selUp);
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tourney_pkg::*;
#(
  parameter int PC_W      = 30,
  parameter int GH_W      = 10,
  parameter int LH_W      = 10,
  parameter int LHT_IDX_W = 10,
  parameter int SEL_IDX_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  output logic            predGlobal,
  output logic            predLocal,
  output logic            predUseGlobal,
  output logic [GH_W-1:0] lookupGhist,
  output logic [LH_W-1:0] lookupLhist,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [GH_W-1:0] updGhist,
  input  logic [LH_W-1:0] updLhist,
  input  logic            updPredGlobal,
  input  logic            updPredLocal
);
  bpStrobes_t strobes;

  tourney_ctl ctl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updPredGlobal (updPredGlobal),
    .updPredLocal  (updPredLocal),
    .strobes       (strobes)
  );

  tourney_dp #(
    .PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W),
    .LHT_IDX_W(LHT_IDX_W), .SEL_IDX_W(SEL_IDX_W)
  ) dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .lookupPc      (lookupPc),
    .predGlobal    (predGlobal),
    .predLocal     (predLocal),
    .predUseGlobal (predUseGlobal),
    .lookupGhist   (lookupGhist),
    .lookupLhist   (lookupLhist),
    .updPc         (updPc),
    .updTaken      (updTaken),
    .updGhist      (updGhist),
    .updLhist      (updLhist)
  );

  // R7: chooser upper bit steers the final direction
  assign predTaken = predUseGlobal ? predGlobal : predLocal;
endmodule

// File: rtl/tourney_chk.sv
module tourney_chk #(
  parameter int PC_W = 30,
  parameter int GH_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic [GH_W-1:0] lookupGhist,
  input logic            predUseGlobal,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic            updPredGlobal,
  input logic            updPredLocal
);
  a_r3_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> lookupGhist == {$past(lookupGhist[GH_W-2:0]), $past(updTaken)});

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(lookupGhist));

  a_r6_agree_hold: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPredGlobal == updPredLocal && lookupPc == updPc)
      |=> (lookupPc != $past(lookupPc) || predUseGlobal == $past(predUseGlobal)));

  a_r5_reward_global: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPredGlobal == updTaken && updPredLocal != updTaken &&
     lookupPc == updPc && predUseGlobal)
      |=> (lookupPc != $past(lookupPc) || predUseGlobal));

  a_r5_reward_local: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPredLocal == updTaken && updPredGlobal != updTaken &&
     lookupPc == updPc && !predUseGlobal)
      |=> (lookupPc != $past(lookupPc) || !predUseGlobal));
endmodule

bind tourney_bp tourney_chk #(.PC_W(PC_W), .GH_W(GH_W)) chk (
  .clk           (clk),
  .rstN          (rstN),
  .lookupPc      (lookupPc),
  .lookupGhist   (lookupGhist),
  .predUseGlobal (predUseGlobal),
  .updValid      (updValid),
  .updPc         (updPc),
  .updTaken      (updTaken),
  .updPredGlobal (updPredGlobal),
  .updPredLocal  (updPredLocal)
);

// File: tb/tourney_bp_test.sv
module tourney_bp_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam int HW = 2;
  localparam int NROWS = 9;

  // row: pc[12:11] gh[10:9] lh[8:7] pG pL use fin taken upG upL
  localparam logic [12:0] ROWS [NROWS] = '{
    13'b01_00_00_0_0_0_0_1_0_0,
    13'b01_01_01_0_0_0_0_1_1_0,
    13'b01_11_11_0_0_1_0_0_1_0,
    13'b10_10_00_0_1_0_1_1_1_1,
    13'b10_01_01_1_1_0_1_1_1_0,
    13'b10_11_11_0_0_1_0_1_1_0,
    13'b10_11_11_0_0_1_0_1_1_0,
    13'b10_11_11_1_1_1_1_0_1_0,
    13'b10_10_10_1_0_1_1_0_0_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0, updPc = '0;
  logic predTaken, predGlobal, predLocal, predUseGlobal;
  logic [HW-1:0] lookupGhist, lookupLhist;
  logic updValid = 1'b0, updTaken = 1'b0, updPredGlobal = 1'b0, updPredLocal = 1'b0;
  logic [HW-1:0] updGhist = '0, updLhist = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .GH_W(HW), .LH_W(HW), .LHT_IDX_W(HW), .SEL_IDX_W(HW)) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .predGlobal(predGlobal), .predLocal(predLocal), .predUseGlobal(predUseGlobal),
    .lookupGhist(lookupGhist), .lookupLhist(lookupLhist), .updValid(updValid),
    .updPc(updPc), .updTaken(updTaken), .updGhist(updGhist), .updLhist(updLhist),
    .updPredGlobal(updPredGlobal), .updPredLocal(updPredLocal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectAll(input string ctx, input logic [1:0] gh, input logic [1:0] lh,
                           input logic pg, input logic pl, input logic ug, input logic fin);
    chk({ctx, " R3 ghist"}, lookupGhist, gh);
    chk({ctx, " R4 lhist"}, lookupLhist, lh);
    chk({ctx, " R2 global"}, predGlobal, pg);
    chk({ctx, " R2/R8 local"}, predLocal, pl);
    chk({ctx, " R5/R6 chooser"}, predUseGlobal, ug);
    chk({ctx, " R7 final"}, predTaken, fin);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    lookupPc = 8'd1;
    #1 expectAll("R1 reset", 2'b00, 2'b00, 0, 0, 0, 0);
    rstN = 1'b1;

    // table walk: lookup and update of the same slot in one cycle (R10)
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      lookupPc = {6'b0, ROWS[i][12:11]};
      updPc = lookupPc;
      updGhist = ROWS[i][10:9];
      updLhist = ROWS[i][8:7];
      updTaken = ROWS[i][2];
      updPredGlobal = ROWS[i][1];
      updPredLocal = ROWS[i][0];
      updValid = 1'b1;
      #1 expectAll($sformatf("row%0d", i), ROWS[i][10:9], ROWS[i][8:7],
                   ROWS[i][6], ROWS[i][5], ROWS[i][4], ROWS[i][3]);
    end

    // R9: strobe low, other update fields active
    @(negedge clk);
    updValid = 1'b0;
    updTaken = 1'b1; updPredGlobal = 1'b1; updPredLocal = 1'b0;
    updGhist = 2'b11; updLhist = 2'b11;
    @(negedge clk);
    lookupPc = 8'd2;
    #1 expectAll("R9 idle", 2'b00, 2'b00, 1, 1, 1, 1);

    // R10: same-cycle update, old state before the edge, new state after
    updPc = 8'd2; updGhist = 2'b00; updLhist = 2'b00;
    updTaken = 1'b1; updPredGlobal = 1'b1; updPredLocal = 1'b1;
    updValid = 1'b1;
    #1 expectAll("R10 before", 2'b00, 2'b00, 1, 1, 1, 1);
    @(negedge clk);
    updValid = 1'b0;
    #1 expectAll("R10 after", 2'b01, 2'b01, 1, 1, 1, 1);

    // R1: reset again clears trained state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1 expectAll("R1 rereset", 2'b00, 2'b00, 0, 0, 0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule